// File: doc/BRIEF.md
# Memory Bus Cycle Controller

This block is the processor-side master of a parallel memory bus. A request arrives on a simple port as an operation type, an address and the data to write. The controller then runs one complete bus cycle toward a slow memory. It presents the address first. It then pulls the active-low read or write strobe and, for a write, drives the data bus. It holds everything until the memory raises its ready line. When the cycle ends it releases the strobe and reports completion with a one-clock done pulse. For a read, the returned word is also presented at that point.

Only one cycle is in flight at any time. A request that arrives while a cycle is running is dropped, and a one-clock rejected flag reports it. The strobe always stays low for at least one wait state. If ready never comes, a timeout counter ends the cycle and raises an error flag alongside done.

Top module: `memBusMaster`

## Requirements
- R1: After reset both strobes are high (inactive), the data output enable is low, and done, error and rejected are all low.
- R2: A request sampled while idle starts an address phase in the next cycle. In that phase the bus address equals the requested address and both strobes stay high.
- R3: In a read, the read strobe goes low in the cycle after the address phase. Ready is ignored in that first strobe cycle, so the strobe stays low for at least two cycles. It stays low up to and including the cycle in which ready is sampled high.
- R4: Read data is taken from the data input on the clock edge where ready is sampled high. It appears on the response data output together with done and holds until the next successful read.
- R5: In a write, the write strobe goes low and the output enable goes high over exactly the same cycles. During those cycles the data output equals the requested write data. The enable is low in every other cycle.
- R6: The bus address does not change from the address phase to the last strobe cycle.
- R7: Done is high for exactly one cycle: the cycle after the edge on which the cycle ended. Both strobes are already high in that cycle.
- R8: TIMEOUT_CYCLES (default 8) limits the strobe. If ready has not been seen in strobe cycles 2 through TIMEOUT_CYCLES, the cycle ends after strobe cycle TIMEOUT_CYCLES. Done and error are then both high for one cycle, and read data is left unchanged.
- R9: A request sampled while not idle has no effect on the bus or on the cycle in progress. The rejected flag is high in the following cycle.
- R10: The controller is idle again in the cycle in which done is high, so a request made in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled each clock |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| rspRdata | output | DATA_W | Last word read |
| rspDone | output | 1 | One-clock completion pulse |
| rspError | output | 1 | Cycle ended by timeout (with done) |
| reqRejected | output | 1 | Request arrived while busy |
| busAddr | output | ADDR_W | Bus address |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busDout | output | DATA_W | Bus write data |
| busDoutEn | output | 1 | Output enable for busDout (low means released) |
| busDin | input | DATA_W | Bus read data |
| busReady | input | 1 | Memory ready, ends wait states |

## Verification
Reads and writes run with the memory answering at once, after a few wait states, and never. Answering at once shows that ready is ignored in the first strobe cycle. The longer waits show the stretch is open-ended, and silence separates a timeout from a normal end. The data input changes every cycle, so a capture one edge early or late shows up as a wrong read word. Requests made during the address and strobe phases, and a request made in the done cycle, tell a busy master from an idle one. A random mix of operations and delays, checked against a reference model every clock, covers orderings that the directed cases miss.

// File: rtl/memBusPkg.sv
package memBusPkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_STROBE = 2'd2
  } busPhase_t;

  typedef struct packed {
    logic loadReq;
    logic captureRd;
    logic rdActive;
    logic wrActive;
  } pathCtl_t;

endpackage

// File: rtl/memBusCtrl.sv
module memBusCtrl
  import memBusPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     busReady,
  output pathCtl_t ctl,
  output logic     rspDone,
  output logic     rspError,
  output logic     reqRejected,
  output logic     busRdN,
  output logic     busWrN
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(TIMEOUT_CYCLES - 1);

  busPhase_t phase;
  logic      isWrite;
  logic [CW-1:0] waitCnt;
  logic      readyOk;
  logic      expire;

  always_comb begin
    readyOk       = (waitCnt != '0) && busReady;
    expire        = (waitCnt == LAST_WAIT);
    ctl.loadReq   = (phase == PH_IDLE) && reqValid;
    ctl.rdActive  = (phase == PH_STROBE) && !isWrite;
    ctl.wrActive  = (phase == PH_STROBE) && isWrite;
    ctl.captureRd = ctl.rdActive && readyOk;
    busRdN        = !ctl.rdActive;
    busWrN        = !ctl.wrActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      isWrite     <= 1'b0;
      waitCnt     <= '0;
      rspDone     <= 1'b0;
      rspError    <= 1'b0;
      reqRejected <= 1'b0;
    end else begin
      rspDone     <= 1'b0;
      rspError    <= 1'b0;
      reqRejected <= reqValid && (phase != PH_IDLE);
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase   <= PH_ADDR;
            isWrite <= reqWrite;
          end
        end
        PH_ADDR: begin
          phase   <= PH_STROBE;
          waitCnt <= '0;
        end
        PH_STROBE: begin
          if (readyOk) begin
            phase   <= PH_IDLE;
            rspDone <= 1'b1;
          end else if (expire) begin
            phase    <= PH_IDLE;
            rspDone  <= 1'b1;
            rspError <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: a falling read strobe stays low for at least one more cycle
  a_r3_min_wait: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdN) |=> !busRdN);

  // R5: same minimum wait state on the write side
  a_r5_min_wait_wr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWrN) |=> !busWrN);

  // R9: a request while busy is flagged next cycle
  a_r9_busy_flag: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && phase != PH_IDLE) |=> reqRejected);

  // R8: error only comes with done
  a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspDone);

  // R7: strobes are released while done is shown
  a_r7_released_at_done: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (busRdN && busWrN));

endmodule

// File: rtl/memBusPath.sv
module memBusPath
  import memBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (ctl.captureRd) begin
        rdataReg <= busDin;
      end
    end
  end

  always_comb begin
    busAddr   = addrReg;
    busDoutEn = ctl.wrActive;
    busDout   = ctl.wrActive ? wdataReg : '0;
    rspRdata  = rdataReg;
  end

  // R6: address held while any strobe is active
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdActive || ctl.wrActive) |-> $stable(busAddr));

  // R5: driven write data does not move while enabled
  a_r5_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busDoutEn && $past(busDoutEn)) |-> $stable(busDout));

  // R4: read data changes only through a capture
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.captureRd) |-> $stable(rspRdata));

endmodule

// File: rtl/memBusMaster.sv
module memBusMaster
  import memBusPkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int TIMEOUT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic              rspError,
  output logic              reqRejected,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busReady
);

  pathCtl_t ctl;

  memBusCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busReady(busReady), .ctl(ctl), .rspDone(rspDone), .rspError(rspError),
    .reqRejected(reqRejected), .busRdN(busRdN), .busWrN(busWrN)
  );

  memBusPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busDin(busDin), .busAddr(busAddr), .busDout(busDout),
    .busDoutEn(busDoutEn), .rspRdata(rspRdata)
  );

  // R7: done never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: tb/memBusMaster_test.sv
module memBusMaster_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspRdata, busDout;
  logic rspDone, rspError, reqRejected, busRdN, busWrN, busDoutEn;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDin = '0;
  logic busReady = 1'b0;

  int total = 0, bad = 0;
  int readyDelay = 1;
  int strobeCnt = 0;
  bit finished = 0;

  // reference model state
  int mPhase = 0, mCnt = 0;
  bit mWrite = 0, eDone = 0, eErr = 0, eRej = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0, mRdata = '0;

  memBusMaster #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rspDone(rspDone), .rspError(rspError), .reqRejected(reqRejected),
    .busAddr(busAddr), .busRdN(busRdN), .busWrN(busWrN), .busDout(busDout),
    .busDoutEn(busDoutEn), .busDin(busDin), .busReady(busReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mWrite = 0; mAddr = '0; mData = '0; mRdata = '0;
      eDone = 0; eErr = 0; eRej = 0;
    end else begin
      eRej = reqValid && (mPhase != 0);
      eDone = 0; eErr = 0;
      case (mPhase)
        0: if (reqValid) begin
             mPhase = 1; mWrite = reqWrite; mAddr = reqAddr; mData = reqWdata;
           end
        1: begin mPhase = 2; mCnt = 0; end
        default: begin
          if (mCnt >= 1 && busReady) begin
            eDone = 1; if (!mWrite) mRdata = busDin; mPhase = 0;
          end else if (mCnt == TO - 1) begin
            eDone = 1; eErr = 1; mPhase = 0;
          end else mCnt++;
        end
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R3", "busRdN", 32'(busRdN), 32'(!(mPhase == 2 && !mWrite)));
      check("R5", "busWrN", 32'(busWrN), 32'(!(mPhase == 2 && mWrite)));
      check("R5", "busDoutEn", 32'(busDoutEn), 32'(mPhase == 2 && mWrite));
      if (mPhase == 2 && mWrite) check("R5", "busDout", 32'(busDout), 32'(mData));
      if (mPhase == 1) check("R2", "busAddr", 32'(busAddr), 32'(mAddr));
      if (mPhase == 2) check("R6", "busAddr", 32'(busAddr), 32'(mAddr));
      check("R7", "rspDone", 32'(rspDone), 32'(eDone));
      check("R8", "rspError", 32'(rspError), 32'(eErr));
      check("R4", "rspRdata", 32'(rspRdata), 32'(mRdata));
      check("R9", "reqRejected", 32'(reqRejected), 32'(eRej));
    end
  end

  // memory side: ready after readyDelay strobe cycles, changing read data
  always @(negedge clk) begin
    busDin = DW'($urandom);
    if (!busRdN || !busWrN) strobeCnt = strobeCnt + 1;
    else strobeCnt = 0;
    busReady = (strobeCnt != 0) && (strobeCnt >= readyDelay);
  end

  task automatic issue(input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int dly);
    readyDelay = dly;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!rspDone) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "busRdN", 32'(busRdN), 32'd1);
    check("R1", "busWrN", 32'(busWrN), 32'd1);
    check("R1", "busDoutEn", 32'(busDoutEn), 32'd0);
    check("R1", "rspDone", 32'(rspDone), 32'd0);
    check("R1", "rspError", 32'(rspError), 32'd0);
    check("R1", "reqRejected", 32'(reqRejected), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: ready present in the first strobe cycle is ignored
    issue(0, 16'h1234, 16'h0, 0); waitDone(); @(negedge clk);
    issue(0, 16'h2222, 16'h0, 1); waitDone(); @(negedge clk);
    // R3/R4: several wait states
    issue(0, 16'hABCD, 16'h0, 4); waitDone(); @(negedge clk);
    // R5: writes with different waits
    issue(1, 16'h0F0F, 16'hBEEF, 2); waitDone(); @(negedge clk);
    issue(1, 16'hF00D, 16'h5A5A, 5); waitDone(); @(negedge clk);
    // R8: no ready at all, read then write
    issue(0, 16'h0BAD, 16'h0, 100); waitDone();
    check("R8", "error on read timeout", 32'(rspError), 32'd1);
    @(negedge clk);
    issue(1, 16'h0BAE, 16'h1111, 100); waitDone();
    check("R8", "error on write timeout", 32'(rspError), 32'd1);
    @(negedge clk);
    // R8 boundary: ready arrives in the last allowed strobe cycle
    issue(0, 16'h0C00, 16'h0, TO); waitDone();
    check("R8", "no error at last cycle", 32'(rspError), 32'd0);
    @(negedge clk);

    // R9: requests during address and strobe phases are ignored
    issue(0, 16'h3333, 16'h0, 3);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'hDEAD; reqWdata = 16'hCAFE;
    @(negedge clk);
    check("R9", "rejected after address-phase request", 32'(reqRejected), 32'd1);
    check("R9", "address unchanged", 32'(busAddr), 32'h3333);
    @(negedge clk);
    reqValid = 1'b0;
    check("R9", "still reading", 32'(busRdN), 32'd0);
    waitDone(); @(negedge clk);

    // R10: a request made in the done cycle is accepted
    issue(0, 16'h4444, 16'h0, 2); waitDone();
    issue(1, 16'h5555, 16'h7777, 2);
    check("R10", "back-to-back address phase", 32'(busAddr), 32'h5555);
    check("R10", "back-to-back not rejected", 32'(reqRejected), 32'd0);
    waitDone(); @(negedge clk);

    // random mix
    for (int i = 0; i < 40; i++) begin
      issue(1'($urandom), AW'($urandom), DW'($urandom), int'($urandom_range(0, TO + 2)));
      waitDone();
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule